// File: doc/BRIEF.md
# Output Port Self-Loopback Unit

This unit sits on one output port of a four-port mesh router. Each port of the router has its own copy. It takes flits from the port's output buffer and forwards them to the neighbour router while that neighbour reports itself available. Sometimes the neighbour is unavailable when a packet head is waiting. The cause may be a reconfiguration in progress or a permanent fault. In that case the unit does not let the packet sit in the buffer or get lost. It turns the packet around onto the router's own input bus and marks it as looped, so the crossbar handles it as a new packet and routes it out through another port. While a looped packet is in flight, the unit raises a stop signal toward the neighbour so that no neighbour traffic enters this port in the meantime.

Flits move one per cycle and carry a tail marker. The unit fixes the path (forward or loop) at the packet head and keeps it until the tail has passed. The router input bus is shared between the looped packet and the neighbour's own incoming packets. Packets never interleave on it. A looped head may start only at an incoming packet boundary, and at such a boundary the looped head wins over a new incoming head. Both output paths are registered, so each accepted flit shows up one clock later.

Top module: `lbk_port_unit`

## Requirements
- R1: While reset is asserted, link_valid, rin_valid, rin_loop, nbr_stop and obuf_pop are all 0 when obuf_valid and in_valid are 0.
- R2: When the unit is idle and a head flit is waiting with nbr_avail high, obuf_pop is 1 in that cycle, nbr_stop stays 0, and on the next cycle link_valid is 1 with link_data equal to that flit.
- R3: When the unit is idle and a head flit is waiting with nbr_avail low, and no incoming packet is part-way through, obuf_pop and nbr_stop are 1 in that cycle. On the next cycle rin_valid and rin_loop are 1 with rin_data equal to that flit, and link_valid is 0.
- R4: From the cycle the looped head is popped until the cycle its tail flit is popped, inclusive, nbr_stop is 1 in every cycle, including cycles in which the buffer is empty. It is 0 in the cycle after the tail when no new loop starts.
- R5: An incoming flit offered while nbr_stop is 1 is not taken. On the next cycle rin_valid is 0 or rin_loop is 1.
- R6: When a looped head and a new incoming head (in_valid with no incoming packet part-way through) arrive in the same cycle, the looped head goes onto the router input bus.
- R7: While an incoming packet has passed its head but not its tail, a waiting head with nbr_avail low is not popped (obuf_pop 0, nbr_stop 0). The loop starts in the first cycle after the incoming tail.
- R8: The path is fixed per packet. Once a head is forwarded, later flits go only to the link. Once a head is looped, later flits loop even if nbr_avail returns high.
- R9: If nbr_avail returns high while a head is still waiting to start a loop, the packet is forwarded on the link and nothing is looped.
- R10: Incoming flits taken while nbr_stop is 0 appear on the router input bus one cycle later, with unchanged data and rin_loop 0.
- R11: During a forwarded packet, a cycle with nbr_avail low pops nothing, and on the next cycle link_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obuf_valid | input | 1 | Output buffer holds a flit |
| obuf_data | input | DATA_W | Flit payload at the output buffer head |
| obuf_tail | input | 1 | Buffer head flit is the last of its packet |
| obuf_pop | output | 1 | Buffer head flit is consumed this cycle |
| nbr_avail | input | 1 | Downstream neighbour is able to receive |
| link_valid | output | 1 | Flit sent toward the neighbour |
| link_data | output | DATA_W | Payload sent toward the neighbour |
| link_tail | output | 1 | Tail marker sent toward the neighbour |
| in_valid | input | 1 | Neighbour offers an incoming flit |
| in_data | input | DATA_W | Incoming flit payload |
| in_tail | input | 1 | Incoming flit is a tail |
| nbr_stop | output | 1 | Tells the neighbour to hold its flits |
| rin_valid | output | 1 | Router input bus carries a flit |
| rin_data | output | DATA_W | Router input bus payload |
| rin_tail | output | 1 | Router input bus tail marker |
| rin_loop | output | 1 | Router input flit is a looped-back one |

## Verification
The bench sweeps packet lengths of one to four flits through both the forward path and the loop path, with single-flit incoming traffic offered in every cycle. This catches a unit that forgets the stop signal during a loop or lets neighbour flits slip onto the bus mid-loop. It also covers an incoming packet that is part-way through when a loop is wanted. A design that ignores packet boundaries would interleave two packets on the router input bus, and one that decides only once would loop a packet whose neighbour has already come back. Mid-packet changes of neighbour availability expose a unit that switches path inside a packet, forwards to an absent neighbour, or drops its stop signal during an empty-buffer bubble.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef enum logic [1:0] {
        PATH_IDLE = 2'd0,
        PATH_FWD  = 2'd1,
        PATH_LOOP = 2'd2
    } path_e;

    typedef struct packed {
        path_e path;
        logic  in_mid;
    } ctrl_t;

endpackage

// File: rtl/lbk_path_ctrl.sv
module lbk_path_ctrl
    import lbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic obuf_valid,
    input  logic obuf_tail,
    input  logic nbr_avail,
    input  logic in_valid,
    input  logic in_tail,
    output logic fwd_go,
    output logic lb_go,
    output logic in_take,
    output logic stop
);

    ctrl_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        fwd_go = 1'b0;
        lb_go  = 1'b0;
        case (st_q.path)
            PATH_IDLE: begin
                if (obuf_valid) begin
                    if (nbr_avail) begin
                        fwd_go = 1'b1;
                        if (!obuf_tail) st_d.path = PATH_FWD;
                    end else if (!st_q.in_mid) begin
                        lb_go = 1'b1;
                        if (!obuf_tail) st_d.path = PATH_LOOP;
                    end
                end
            end
            PATH_FWD: begin
                if (obuf_valid && nbr_avail) begin
                    fwd_go = 1'b1;
                    if (obuf_tail) st_d.path = PATH_IDLE;
                end
            end
            PATH_LOOP: begin
                if (obuf_valid) begin
                    lb_go = 1'b1;
                    if (obuf_tail) st_d.path = PATH_IDLE;
                end
            end
            default: st_d.path = PATH_IDLE;
        endcase
        // neighbour held for the whole looped packet, bubbles included
        stop    = lb_go | (st_q.path == PATH_LOOP);
        in_take = in_valid & ~stop;
        if (in_take) st_d.in_mid = ~in_tail;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.path   <= PATH_IDLE;
            st_q.in_mid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lbk_rin_mux.sv
module lbk_rin_mux #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_go,
    input  logic              in_take,
    input  logic [DATA_W-1:0] lb_data,
    input  logic              lb_tail,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_tail,
    output logic              rin_valid,
    output logic [DATA_W-1:0] rin_data,
    output logic              rin_tail,
    output logic              rin_loop
);

    typedef struct packed {
        logic              valid;
        logic              loop;
        logic              tail;
        logic [DATA_W-1:0] data;
    } rin_t;

    rin_t r_q, r_d;

    always_comb begin
        r_d.valid = lb_go | in_take;
        r_d.loop  = lb_go;
        r_d.tail  = lb_go ? lb_tail : in_tail;
        r_d.data  = lb_go ? lb_data : in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rin_valid = r_q.valid;
    assign rin_loop  = r_q.loop;
    assign rin_tail  = r_q.tail;
    assign rin_data  = r_q.data;

endmodule

// File: rtl/lbk_link_reg.sv
module lbk_link_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] data_in,
    input  logic              tail_in,
    output logic              link_valid,
    output logic [DATA_W-1:0] link_data,
    output logic              link_tail
);

    localparam int FLIT_W = DATA_W + 2;

    logic [FLIT_W-1:0] l_q, l_d;

    always_comb begin
        l_d = {go, tail_in, data_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign link_valid = l_q[FLIT_W-1];
    assign link_tail  = l_q[FLIT_W-2];
    assign link_data  = l_q[DATA_W-1:0];

endmodule

// File: rtl/lbk_port_unit.sv
module lbk_port_unit #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obuf_valid,
    input  logic [DATA_W-1:0] obuf_data,
    input  logic              obuf_tail,
    output logic              obuf_pop,
    input  logic              nbr_avail,
    output logic              link_valid,
    output logic [DATA_W-1:0] link_data,
    output logic              link_tail,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_tail,
    output logic              nbr_stop,
    output logic              rin_valid,
    output logic [DATA_W-1:0] rin_data,
    output logic              rin_tail,
    output logic              rin_loop
);

    logic fwd_go, lb_go, in_take;

    lbk_path_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .obuf_valid (obuf_valid),
        .obuf_tail  (obuf_tail),
        .nbr_avail  (nbr_avail),
        .in_valid   (in_valid),
        .in_tail    (in_tail),
        .fwd_go     (fwd_go),
        .lb_go      (lb_go),
        .in_take    (in_take),
        .stop       (nbr_stop)
    );

    lbk_rin_mux #(.DATA_W(DATA_W)) u_rin (
        .clk       (clk),
        .rst_n     (rst_n),
        .lb_go     (lb_go),
        .in_take   (in_take),
        .lb_data   (obuf_data),
        .lb_tail   (obuf_tail),
        .in_data   (in_data),
        .in_tail   (in_tail),
        .rin_valid (rin_valid),
        .rin_data  (rin_data),
        .rin_tail  (rin_tail),
        .rin_loop  (rin_loop)
    );

    lbk_link_reg #(.DATA_W(DATA_W)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (fwd_go),
        .data_in    (obuf_data),
        .tail_in    (obuf_tail),
        .link_valid (link_valid),
        .link_data  (link_data),
        .link_tail  (link_tail)
    );

    assign obuf_pop = fwd_go | lb_go;

endmodule

// File: rtl/lbk_port_unit_chk.sv
module lbk_port_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              obuf_valid,
    input logic [DATA_W-1:0] obuf_data,
    input logic              obuf_pop,
    input logic              nbr_avail,
    input logic              nbr_stop,
    input logic              link_valid,
    input logic [DATA_W-1:0] link_data,
    input logic              rin_valid,
    input logic [DATA_W-1:0] rin_data,
    input logic              rin_loop
);

    p_fwd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (obuf_pop && !nbr_stop) |=> (link_valid && link_data == $past(obuf_data)));

    p_loop_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (obuf_pop && nbr_stop) |=> (rin_valid && rin_loop && rin_data == $past(obuf_data)));

    p_stop_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nbr_stop |=> !(rin_valid && !rin_loop));

    p_fwd_needs_nbr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (obuf_pop && !nbr_stop) |-> nbr_avail);

    p_one_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_valid && rin_loop));

    p_pop_has_flit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        obuf_pop |-> obuf_valid);

endmodule

bind lbk_port_unit lbk_port_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .obuf_valid (obuf_valid),
    .obuf_data  (obuf_data),
    .obuf_pop   (obuf_pop),
    .nbr_avail  (nbr_avail),
    .nbr_stop   (nbr_stop),
    .link_valid (link_valid),
    .link_data  (link_data),
    .rin_valid  (rin_valid),
    .rin_data   (rin_data),
    .rin_loop   (rin_loop)
);

// File: tb/tb_lbk_port_unit.sv
module tb_lbk_port_unit;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic obuf_valid = 0, obuf_tail = 0, nbr_avail = 0;
    logic in_valid = 0, in_tail = 0;
    logic [W-1:0] obuf_data = '0, in_data = '0;
    logic obuf_pop, link_valid, link_tail, nbr_stop, rin_valid, rin_tail, rin_loop;
    logic [W-1:0] link_data, rin_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lbk_port_unit #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .obuf_valid(obuf_valid), .obuf_data(obuf_data), .obuf_tail(obuf_tail), .obuf_pop(obuf_pop),
        .nbr_avail(nbr_avail),
        .link_valid(link_valid), .link_data(link_data), .link_tail(link_tail),
        .in_valid(in_valid), .in_data(in_data), .in_tail(in_tail),
        .nbr_stop(nbr_stop),
        .rin_valid(rin_valid), .rin_data(rin_data), .rin_tail(rin_tail), .rin_loop(rin_loop)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: drive, check combinational, then check registered outputs
    task automatic cyc(input logic ov, input logic [W-1:0] od, input logic ot, input logic av,
                       input logic iv, input logic [W-1:0] id, input logic it,
                       input logic e_pop, input logic e_stop,
                       input logic e_lv, input logic [W-1:0] e_ld,
                       input logic e_rv, input logic e_rl, input logic [W-1:0] e_rd,
                       input string tag);
        obuf_valid = ov; obuf_data = od; obuf_tail = ot; nbr_avail = av;
        in_valid = iv; in_data = id; in_tail = it;
        #2;
        chk({tag, " pop"}, obuf_pop, e_pop);
        chk({tag, " stop"}, nbr_stop, e_stop);
        @(posedge clk); #1;
        chk({tag, " link_valid"}, link_valid, e_lv);
        if (e_lv) chk({tag, " link_data"}, link_data, e_ld);
        chk({tag, " rin_valid"}, rin_valid, e_rv);
        if (e_rv) begin
            chk({tag, " rin_loop"}, rin_loop, e_rl);
            chk({tag, " rin_data"}, rin_data, e_rd);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 link_valid", link_valid, 0);
        chk("R1 rin_valid", rin_valid, 0);
        chk("R1 rin_loop", rin_loop, 0);
        chk("R1 stop", nbr_stop, 0);
        chk("R1 pop", obuf_pop, 0);
        rst_n = 1'b1;

        // R2 / R10: forward sweep with incoming single-flit traffic alongside
        for (int len = 1; len <= 4; len++) begin
            for (int i = 0; i < len; i++) begin
                logic [W-1:0] f = W'(16'h1000 + len * 16 + i);
                logic [W-1:0] x = W'(16'h2000 + len * 16 + i);
                cyc(1, f, (i == len - 1), 1, 1, x, 1,
                    1, 0, 1, f, 1, 0, x, "R2 R10 fwd");
            end
        end

        // R3 / R4 / R5 / R6: loop sweep against incoming heads every cycle
        for (int len = 1; len <= 4; len++) begin
            for (int i = 0; i < len; i++) begin
                logic [W-1:0] f = W'(16'h3000 + len * 16 + i);
                logic [W-1:0] x = W'(16'h4000 + len * 16 + i);
                cyc(1, f, (i == len - 1), 0, 1, x, 1,
                    1, 1, 0, '0, 1, 1, f, (i == 0) ? "R3 R6 loop head" : "R4 R5 loop body");
            end
            cyc(0, '0, 0, 0, 1, W'(16'h4F00 + len), 1,
                0, 0, 0, '0, 1, 0, W'(16'h4F00 + len), "R4 R10 after tail");
        end

        // R7: incoming packet part-way through defers the loop
        cyc(0, '0, 0, 0, 1, 16'h5A00, 0, 0, 0, 0, '0, 1, 0, 16'h5A00, "R10 in head");
        cyc(1, 16'h5B00, 1, 0, 1, 16'h5A01, 0, 0, 0, 0, '0, 1, 0, 16'h5A01, "R7 deferred");
        cyc(1, 16'h5B00, 1, 0, 1, 16'h5A02, 1, 0, 0, 0, '0, 1, 0, 16'h5A02, "R7 deferred tail");
        cyc(1, 16'h5B00, 1, 0, 0, '0, 0, 1, 1, 0, '0, 1, 1, 16'h5B00, "R7 loop after tail");

        // R9: neighbour returns while the loop is still deferred
        cyc(0, '0, 0, 0, 1, 16'h6A00, 0, 0, 0, 0, '0, 1, 0, 16'h6A00, "R10 in head");
        cyc(1, 16'h6B00, 1, 0, 1, 16'h6A01, 1, 0, 0, 0, '0, 1, 0, 16'h6A01, "R9 deferred");
        cyc(1, 16'h6B00, 1, 1, 0, '0, 0, 1, 0, 1, 16'h6B00, 0, 0, '0, "R9 forwarded");

        // R8 / R11: forward packet with a gap in availability
        cyc(1, 16'h7000, 0, 1, 0, '0, 0, 1, 0, 1, 16'h7000, 0, 0, '0, "R8 fwd head");
        cyc(1, 16'h7001, 0, 0, 0, '0, 0, 0, 0, 0, '0, 0, 0, '0, "R11 fwd stall");
        cyc(1, 16'h7001, 0, 1, 0, '0, 0, 1, 0, 1, 16'h7001, 0, 0, '0, "R8 fwd body");
        cyc(1, 16'h7002, 1, 1, 0, '0, 0, 1, 0, 1, 16'h7002, 0, 0, '0, "R8 fwd tail");

        // R8 / R4 / R5: looped packet keeps looping after neighbour returns, stop held over a bubble
        cyc(1, 16'h8000, 0, 0, 1, 16'h8A00, 1, 1, 1, 0, '0, 1, 1, 16'h8000, "R3 loop head");
        cyc(0, '0, 0, 1, 1, 16'h8A01, 1, 0, 1, 0, '0, 0, 0, '0, "R4 R5 bubble");
        cyc(1, 16'h8001, 1, 1, 1, 16'h8A02, 1, 1, 1, 0, '0, 1, 1, 16'h8001, "R8 loop tail");
        cyc(0, '0, 0, 1, 1, 16'h8A03, 1, 0, 0, 0, '0, 1, 0, 16'h8A03, "R4 R10 released");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule